// File: doc/BRIEF.md
# Write-once system configuration register with stop-exit recovery timer

This block holds the system configuration byte of a small microcontroller core. It sits on a simple register bus at address 0x19. Three of its bits are protected: the stop permission, the length of the stop-exit delay and the watchdog enable. Each protected bit takes the first value written after reset and then ignores later writes until the next reset. The fourth bit selects internal read visibility and can be rewritten at any time.

The block also sequences stop mode. When the core reports a STOP instruction and stopping is permitted, the run enable drops. A later wake event starts a recovery count of 1024 or 4064 bus cycles, and program execution resumes when that count ends. When stopping is not permitted, the block issues a one-cycle reset request instead.

Top module: `sysconf_reg`

## Requirements
- R1: After reset, every configuration bit and output reads 0, run_en is 1, rst_req is 0, and all write-once locks are released.
- R2: A read at address 0x19 returns, combinationally, {4'b0, rd_vis, wdog_en, rec_long, stop_en}, with stop_en in bit 0 and rd_vis in bit 3. Any other address reads 0.
- R3: Bits 0, 1 and 2 take their values from the first write to 0x19 after reset. Each has its own lock, and later writes leave these bits unchanged.
- R4: Bit 3 (rd_vis) takes the written value on every write to 0x19.
- R5: A write to any address other than 0x19 changes no bit.
- R6: While running, a stop_exec pulse with stop_en=1 drives run_en to 0 from the next clock edge.
- R7: While running, a stop_exec pulse with stop_en=0 gives rst_req=1 for exactly one cycle after the next edge, and run_en stays 1.
- R8: With rec_long=0 when a wake is sampled in stop, run_en returns to 1 exactly 1024 clock edges after the edge that sampled the wake.
- R9: With rec_long=1 when a wake is sampled, the same delay is 4064 edges.
- R10: cfg_stop_en, cfg_rec_long, cfg_wdog_en and cfg_rd_vis always equal register bits 0, 1, 2 and 3.
- R11: A stop_exec in the same cycle as a write to 0x19 is judged by the stop_en value held before that write.
- R12: A stop_exec during stop or recovery is ignored, and so is a wake while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 8 | Read data, combinational on bus_addr |
| stop_exec | input | 1 | Pulse: STOP instruction executed |
| wake | input | 1 | Pulse: stop-exit event |
| run_en | output | 1 | High while program execution may proceed |
| rst_req | output | 1 | One-cycle system reset request |
| cfg_stop_en | output | 1 | Stop mode permitted |
| cfg_rec_long | output | 1 | Long stop-exit delay selected |
| cfg_wdog_en | output | 1 | Watchdog enable |
| cfg_rd_vis | output | 1 | Internal read visibility control |

## Verification
Two events can land in the same clock: a register write that changes stop_en, and a STOP pulse. The bench provokes this on purpose by writing 0x01 right after reset while stop_exec is high. It then expects a reset request rather than a stop, because the old stop_en was 0, and it expects the register to still latch the new value. A random phase also interleaves writes at several addresses with occasional resets and compares the outcome against a bench model of the locks.

// File: rtl/sysconf_pkg.sv
// Shared types for the system configuration register.
// Assumes a four-bit configuration field in the low bits of the data bus.
package sysconf_pkg;
    localparam int CFG_W  = 4;
    localparam int PROT_W = 3;   // bits 0..2 are write-once

    typedef struct packed {
        logic rd_vis;    // bit 3
        logic wdog_en;   // bit 2
        logic rec_long;  // bit 1
        logic stop_en;   // bit 0
    } cfg_t;
endpackage

// File: rtl/sysconf_wo_reg.sv
// Configuration storage with a per-bit write-once lock on the protected bits.
// Assumes one-cycle write strobes and a synchronous active-low reset that
// clears the bits and releases the locks.
module sysconf_wo_reg
    import sysconf_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              we,
    output cfg_t              cfg
);
    logic              hit_wr;
    logic [CFG_W-1:0]  bits_q;

    assign hit_wr = we && (addr == REG_ADDR);
    assign cfg    = cfg_t'(bits_q);

    for (genvar i = 0; i < PROT_W; i++) begin : g_prot
        logic lock_q;
        // Capture the first write after reset, then hold until reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_q[i] <= 1'b0;
                lock_q    <= 1'b0;
            end else if (hit_wr && !lock_q) begin
                bits_q[i] <= wdata[i];
                lock_q    <= 1'b1;
            end
        end
    end

    for (genvar j = PROT_W; j < CFG_W; j++) begin : g_free
        // Unprotected bits follow every write.
        always_ff @(posedge clk) begin
            if (!rst_n)      bits_q[j] <= 1'b0;
            else if (hit_wr) bits_q[j] <= wdata[j];
        end
    end
endmodule

// File: rtl/sysconf_stop_seq.sv
// Stop-mode sequencer. A STOP pulse either halts execution or asks for a
// reset. A wake in halt starts a recovery countdown whose length is
// chosen at wake time. Assumes stop_exec and wake are single-cycle pulses.
module sysconf_stop_seq #(
    parameter int REC_SHORT = 1024,
    parameter int REC_LONG  = 4064
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_exec,
    input  logic wake,
    input  logic stop_en,
    input  logic rec_long,
    output logic run_en,
    output logic rst_req
);
    localparam int CNT_W = $clog2(REC_LONG + 1);

    typedef enum logic [1:0] {ST_RUN, ST_HALT, ST_RECOV} st_e;
    st_e              st_q;
    logic [CNT_W-1:0] cnt_q;

    assign run_en = (st_q == ST_RUN);

    // Advance the run / halt / recovery state and issue reset requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_RUN;
            cnt_q   <= '0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            case (st_q)
                ST_RUN: begin
                    if (stop_exec) begin
                        if (stop_en) st_q    <= ST_HALT;
                        else         rst_req <= 1'b1;
                    end
                end
                ST_HALT: begin
                    if (wake) begin
                        st_q  <= ST_RECOV;
                        cnt_q <= rec_long ? CNT_W'(REC_LONG - 1) : CNT_W'(REC_SHORT - 1);
                    end
                end
                ST_RECOV: begin
                    if (cnt_q == '0) st_q  <= ST_RUN;
                    else             cnt_q <= cnt_q - 1'b1;
                end
                default: st_q <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/sysconf_reg.sv
// Top of the system configuration block. It gives bus access to the
// write-once configuration byte and drives the stop sequencer from it.
// Assumes reads are combinational and writes take effect at the clock edge.
module sysconf_reg
    import sysconf_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h19,
    parameter int                REC_SHORT = 1024,
    parameter int                REC_LONG  = 4064
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              stop_exec,
    input  logic              wake,
    output logic              run_en,
    output logic              rst_req,
    output logic              cfg_stop_en,
    output logic              cfg_rec_long,
    output logic              cfg_wdog_en,
    output logic              cfg_rd_vis
);
    cfg_t cfg;
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CFG_W];

    sysconf_wo_reg #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .wdata (bus_wdata[CFG_W-1:0]),
        .we    (bus_we),
        .cfg   (cfg)
    );

    sysconf_stop_seq #(.REC_SHORT(REC_SHORT), .REC_LONG(REC_LONG)) u_stop (
        .clk       (clk),
        .rst_n     (rst_n),
        .stop_exec (stop_exec),
        .wake      (wake),
        .stop_en   (cfg.stop_en),
        .rec_long  (cfg.rec_long),
        .run_en    (run_en),
        .rst_req   (rst_req)
    );

    // Combinational read mux: the register at its address, zero elsewhere.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == REG_ADDR) bus_rdata[CFG_W-1:0] = cfg;
    end

    assign cfg_stop_en  = cfg.stop_en;
    assign cfg_rec_long = cfg.rec_long;
    assign cfg_wdog_en  = cfg.wdog_en;
    assign cfg_rd_vis   = cfg.rd_vis;
endmodule

// File: rtl/sysconf_reg_chk.sv
// Assertion checker bound to sysconf_reg. It watches only the top-level ports.
module sysconf_reg_chk #(
    parameter int REC_SHORT = 1024,
    parameter int REC_LONG  = 4064
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic       bus_we,
    input logic       stop_exec,
    input logic       wake,
    input logic       run_en,
    input logic       rst_req,
    input logic       cfg_stop_en,
    input logic       cfg_rec_long,
    input logic       cfg_wdog_en
);
    localparam int CW = $clog2(REC_LONG + 2);

    logic          wr_seen;
    logic          rec_act;
    logic [CW-1:0] rec_cnt;
    logic [CW-1:0] rec_len;

    // Track whether the register was written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                              wr_seen <= 1'b0;
        else if (bus_we && bus_addr == 8'h19)    wr_seen <= 1'b1;
    end

    // Measure the recovery window from the wake to the run_en rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_act <= 1'b0;
            rec_cnt <= '0;
            rec_len <= '0;
        end else if (!rec_act && wake && !run_en) begin
            rec_act <= 1'b1;
            rec_cnt <= '0;
            rec_len <= cfg_rec_long ? CW'(REC_LONG) : CW'(REC_SHORT);
        end else if (rec_act && !run_en) begin
            rec_cnt <= rec_cnt + 1'b1;
        end else if (rec_act && run_en) begin
            rec_act <= 1'b0;
        end
    end

    // R3
    prot_bits_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_seen |=> $stable({cfg_stop_en, cfg_rec_long, cfg_wdog_en}));

    // R6
    stop_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_exec && cfg_stop_en && run_en) |=> !run_en);

    // R7
    stop_denied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_exec && !cfg_stop_en && run_en) |=> (rst_req && run_en));

    // R7
    rst_req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R12
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !stop_exec) |=> run_en);

    // R8 R9
    recovery_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_act && run_en) |-> (rec_cnt == rec_len));
endmodule

bind sysconf_reg sysconf_reg_chk #(.REC_SHORT(REC_SHORT), .REC_LONG(REC_LONG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .stop_exec    (stop_exec),
    .wake         (wake),
    .run_en       (run_en),
    .rst_req      (rst_req),
    .cfg_stop_en  (cfg_stop_en),
    .cfg_rec_long (cfg_rec_long),
    .cfg_wdog_en  (cfg_wdog_en)
);

// File: tb/sysconf_reg_tb.sv
module sysconf_reg_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] RA = 8'h19;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] bus_addr, bus_wdata, bus_rdata;
    logic       bus_we, stop_exec, wake;
    logic       run_en, rst_req;
    logic       cfg_stop_en, cfg_rec_long, cfg_wdog_en, cfg_rd_vis;

    int n_chk = 0;
    int n_fail = 0;

    // Model state: configuration bits and the lock on the protected bits
    logic [3:0] m_val;
    logic       m_lock;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysconf_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .stop_exec(stop_exec), .wake(wake),
        .run_en(run_en), .rst_req(rst_req), .cfg_stop_en(cfg_stop_en),
        .cfg_rec_long(cfg_rec_long), .cfg_wdog_en(cfg_wdog_en), .cfg_rd_vis(cfg_rd_vis)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Bench model of the register value after one write (R3, R4, R5)
    function automatic logic [4:0] model_wr(input logic [4:0] st, input logic [7:0] a,
                                            input logic [7:0] d);
        logic [3:0] v = st[3:0];
        logic       l = st[4];
        if (a == RA) begin
            if (!l) begin
                v[2:0] = d[2:0];
                l = 1'b1;
            end
            v[3] = d[3];
        end
        return {l, v};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        m_val = '0;
        m_lock = 1'b0;
    endtask

    task automatic write(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        tick();
        bus_we = 1'b0;
        {m_lock, m_val} = model_wr({m_lock, m_val}, a, d);
    endtask

    task automatic read_chk(input string req);
        bus_addr = RA;
        #1;
        check(req, bus_rdata, {4'h0, m_val});
    endtask

    task automatic recovery_chk(input string req, input int n);
        bit ok = 1'b1;
        wake = 1'b1;
        tick();
        wake = 1'b0;
        if (run_en !== 1'b0) ok = 1'b0;
        for (int i = 1; i < n; i++) begin
            tick();
            if (run_en !== 1'b0) ok = 1'b0;
        end
        check({req, " early rise"}, ok, 1);
        tick();
        check({req, " rise at end"}, run_en, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 190000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0019));
        bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; stop_exec = 1'b0; wake = 1'b0;
        m_val = '0; m_lock = 1'b0;
        do_reset();

        // R1 reset state
        read_chk("R1 reg after reset");
        check("R1 run_en", run_en, 1);
        check("R1 rst_req", rst_req, 0);
        // R2 other address reads zero
        bus_addr = 8'h18; #1;
        check("R2 other addr read", bus_rdata, 0);

        // R3 R4 first write wins on bits 0..2, bit 3 follows
        write(RA, 8'hFF);
        read_chk("R3 first write");
        write(RA, 8'h00);
        read_chk("R3 R4 second write");
        check("R3 value", {4'h0, m_val}, 8'h07);
        // R5 write elsewhere ignored
        write(8'h18, 8'h08);
        read_chk("R5 foreign write");

        // R11 R7 write and stop in the same cycle; old stop_en=0 decides
        do_reset();
        stop_exec = 1'b1;
        write(RA, 8'h01);
        stop_exec = 1'b0;
        check("R11 R7 rst_req pulse", rst_req, 1);
        check("R11 run_en kept", run_en, 1);
        read_chk("R11 write still latched");
        tick();
        check("R7 rst_req one cycle", rst_req, 0);

        // R12 wake while running ignored
        wake = 1'b1; tick(); wake = 1'b0;
        check("R12 wake while running", run_en, 1);

        // R6 stop entry, then R12 stop while halted ignored
        stop_exec = 1'b1; tick(); stop_exec = 1'b0;
        check("R6 run_en drops", run_en, 0);
        stop_exec = 1'b1; tick(); stop_exec = 1'b0;
        check("R12 stop in halt", {rst_req, run_en}, 0);
        // R8 short recovery
        recovery_chk("R8", 1024);

        // R9 long recovery
        do_reset();
        write(RA, 8'h03);
        stop_exec = 1'b1; tick(); stop_exec = 1'b0;
        check("R6 run_en drops long", run_en, 0);
        recovery_chk("R9", 4064);

        // Random writes with occasional resets (R3 R4 R5 R10 R2)
        for (int k = 0; k < 400; k++) begin
            logic [7:0] a;
            if ($urandom_range(0, 39) == 0) do_reset();
            a = ($urandom_range(0, 9) < 7) ? RA : 8'($urandom_range(0, 255));
            write(a, 8'($urandom));
            read_chk("R3 R4 R5 random read");
            check("R10 cfg outputs", {cfg_rd_vis, cfg_wdog_en, cfg_rec_long, cfg_stop_en},
                  {28'h0, m_val});
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule